// File: doc/BRIEF.md
# Comma-Aligned Deserializer with Framing

This block takes a serial stream of 8B/10B characters, one bit per clock when a valid strobe is high, and packs the bits into parallel words. It can present one 10-bit character per word or two characters per 20-bit word. While framing is enabled, it watches the stream for the positive-disparity comma prefix. When that prefix appears away from the current character boundary, the block moves the boundary so that the comma begins a character, and in the 20-bit mode also begins a word.

A one-cycle word-valid strobe takes the place of a recovered word clock. A SYNC flag marks each word that carries an aligned comma. When framing is disabled, the block never looks for commas. It delivers a word each time a full word of bits has arrived, with boundaries counted from reset.

Moving the boundary never produces a short word period. If the word that would start with the comma would complete with fewer than one word's worth of bits since the previous strobe, the block drops that word. Alignment takes effect from the next word on.

Top module: `comma_deser`

## Requirements
- R1: Within each 10-bit lane, the first-received bit of a character lands in the lowest-numbered bit of that lane.
- R2: With wide_sel=0, each word holds one character in word_out[19:10], word_out[9:0] reads all ones, and word_vld pulses once per 10 accepted bits.
- R3: With wide_sel=1, each word holds two characters, with the earlier one in word_out[9:0] and the later one in word_out[19:10], and word_vld pulses once per 20 accepted bits.
- R4: A comma is seven consecutive received bits 0,0,1,1,1,1,1, in order of arrival, which occupy bit positions 0..6 of their character. The inverted form 1,1,0,0,0,0,0 never moves the boundary.
- R5: With frame_en=1, a comma that arrives off the current boundary makes the comma start a new character. In the 20-bit mode, that character goes to word_out[9:0].
- R6: word_vld never pulses with fewer than one word's worth of accepted bits since the previous pulse or since reset. A realigned word that would be short is dropped.
- R7: sync_out is high together with word_vld for a word that holds an aligned comma, and low for every other word.
- R8: With frame_en=0, the boundary stays where reset put it, words arrive every full word of bits, and sync_out stays low.
- R9: After reset, word_vld, sync_out and word_out are 0 until the first full word is assembled.
- R10: Cycles with bit_vld=0 are ignored: bit_in has no effect in them and they do not count toward a word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_in | input | 1 | Serial data bit |
| bit_vld | input | 1 | bit_in holds a new bit this cycle |
| wide_sel | input | 1 | 1: two characters per word, 0: one character per word |
| frame_en | input | 1 | 1: align to commas, 0: unframed delivery |
| word_out | output | 20 | Parallel word, held between strobes |
| word_vld | output | 1 | One-cycle strobe marking a new word |
| sync_out | output | 1 | The current word holds an aligned comma |

## Verification
The stimulus covers several input patterns:
- A comma sent on the reset boundary establishes bit order and the padding in the narrow mode, with no realignment involved.
- Commas placed three, six and thirteen bits off the boundary separate three outcomes: alignment before any word has been emitted, a realigned word that has to be dropped because it would be short, and a realigned word that is emitted.
- The same stream run with framing disabled, and a stream that carries the inverted comma, both show that the boundary counted from reset is kept and that SYNC stays low.
- In the 20-bit mode, a comma arriving in the second lane must pull the word boundary back to the first lane.
- Idle cycles with random data on bit_in are mixed into every stream.

// File: rtl/cad_pkg.sv
package cad_pkg;
  // Default character geometry for an 8B/10B stream.
  localparam int CAD_CHAR_W  = 10;
  localparam int CAD_COMMA_W = 7;
  localparam int CAD_LANES   = 2;
  // Comma prefix, bit i = i-th received bit: 0,0,1,1,1,1,1.
  localparam logic [CAD_COMMA_W-1:0] CAD_COMMA_PAT = 7'b1111100;

  typedef enum logic {
    WIDTH_SINGLE = 1'b0,
    WIDTH_FULL   = 1'b1
  } width_e;

  // Bits per delivered word for a given width mode.
  function automatic int word_bits(input width_e mode, input int char_w, input int lanes);
    return (mode == WIDTH_FULL) ? char_w * lanes : char_w;
  endfunction
endpackage

// File: rtl/cad_shift.sv
module cad_shift #(
  parameter int CHAR_W = cad_pkg::CAD_CHAR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_in,
  input  logic              bit_vld,
  output logic [CHAR_W-1:0] nxt_win
);
  // Holds the CHAR_W-1 most recent accepted bits; the newest sits on top.
  logic [CHAR_W-2:0] hist_q;

  // Window including the bit on the input: [0] oldest, [CHAR_W-1] newest.
  assign nxt_win = {bit_in, hist_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      hist_q <= '0;
    end else if (bit_vld) begin
      hist_q <= nxt_win[CHAR_W-1:1];
    end
  end
endmodule

// File: rtl/cad_comma_det.sv
module cad_comma_det #(
  parameter int                  CHAR_W    = cad_pkg::CAD_CHAR_W,
  parameter int                  COMMA_W   = cad_pkg::CAD_COMMA_W,
  parameter logic [COMMA_W-1:0]  COMMA_PAT = cad_pkg::CAD_COMMA_PAT
) (
  input  logic [CHAR_W-1:0] nxt_win,
  input  logic              bit_vld,
  input  logic              frame_en,
  output logic              hit
);
  localparam int BASE = CHAR_W - COMMA_W;

  logic [COMMA_W-1:0] match;

  // The newest COMMA_W bits of the window are compared one by one; bit
  // BASE is the earliest of them and faces pattern bit 0.
  for (genvar i = 0; i < COMMA_W; i++) begin : g_cmp
    assign match[i] = (nxt_win[BASE+i] == COMMA_PAT[i]);
  end

  assign hit = bit_vld & frame_en & (&match);
endmodule

// File: rtl/cad_framer.sv
module cad_framer #(
  parameter int CHAR_W  = cad_pkg::CAD_CHAR_W,
  parameter int COMMA_W = cad_pkg::CAD_COMMA_W,
  parameter int LANES   = cad_pkg::CAD_LANES,
  localparam int CW       = $clog2(CHAR_W),
  localparam int LW       = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int WORD_MAX = LANES * CHAR_W,
  localparam int GW       = $clog2(WORD_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bit_vld,
  input  logic          hit,
  input  logic          wide_sel,
  output logic          char_done,
  output logic [LW-1:0] lane,
  output logic          emit,
  output logic          word_comma
);
  import cad_pkg::*;

  width_e        mode;
  logic [CW-1:0] cnt_q;
  logic [LW-1:0] lane_q;
  logic [GW-1:0] gap_q;
  logic          comma_q;
  logic [LW-1:0] lane_top;
  logic [GW-1:0] need_bits;
  logic [GW:0]   gap_inc;
  logic          last_bit;
  logic          word_done;
  logic          gap_ok;

  assign mode      = wide_sel ? WIDTH_FULL : WIDTH_SINGLE;
  assign lane_top  = (mode == WIDTH_FULL) ? LW'(LANES - 1) : '0;
  assign need_bits = GW'(word_bits(mode, CHAR_W, LANES));

  // A character closes when its last bit arrives and no comma restarts it.
  assign last_bit  = (cnt_q == CW'(CHAR_W - 1));
  assign char_done = bit_vld & ~hit & last_bit;
  assign word_done = char_done & (lane_q == lane_top);

  // Bits since the last strobe, counting the one arriving now.
  assign gap_inc   = {1'b0, gap_q} + 1'b1;
  assign gap_ok    = (gap_inc >= {1'b0, need_bits});
  assign emit      = word_done & gap_ok;

  assign lane       = lane_q;
  assign word_comma = comma_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      lane_q  <= '0;
      gap_q   <= '0;
      comma_q <= 1'b0;
    end else if (bit_vld) begin
      if (emit) begin
        gap_q <= '0;
      end else if (gap_q != GW'(WORD_MAX)) begin
        gap_q <= gap_q + 1'b1;
      end

      if (hit) begin
        // Comma prefix complete: the comma now owns a fresh character
        // at the head of a word.
        cnt_q   <= CW'(COMMA_W);
        lane_q  <= '0;
        comma_q <= 1'b1;
      end else if (last_bit) begin
        cnt_q <= '0;
        if (word_done) begin
          lane_q  <= '0;
          comma_q <= 1'b0;
        end else begin
          lane_q <= lane_q + 1'b1;
        end
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/cad_outreg.sv
module cad_outreg #(
  parameter int                 CHAR_W    = cad_pkg::CAD_CHAR_W,
  parameter int                 COMMA_W   = cad_pkg::CAD_COMMA_W,
  parameter int                 LANES     = cad_pkg::CAD_LANES,
  parameter logic [COMMA_W-1:0] COMMA_PAT = cad_pkg::CAD_COMMA_PAT,
  localparam int LW     = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int WORD_W = LANES * CHAR_W,
  localparam int TOP    = (LANES - 1) * CHAR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CHAR_W-1:0] nxt_win,
  input  logic              char_done,
  input  logic [LW-1:0]     lane,
  input  logic              emit,
  input  logic              word_comma,
  input  logic              wide_sel,
  input  logic              frame_en,
  output logic [WORD_W-1:0] word_out,
  output logic              word_vld,
  output logic              sync_out
);
  logic [WORD_W-1:0] assembled;

  // Earlier lanes are buffered as their characters close; the last lane
  // comes straight from the window when the word completes.
  for (genvar l = 0; l < LANES - 1; l++) begin : g_lane
    logic [CHAR_W-1:0] buf_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        buf_q <= '0;
      end else if (char_done && lane == LW'(l)) begin
        buf_q <= nxt_win;
      end
    end
    // In the single-character mode the unused lanes read all ones.
    assign assembled[l*CHAR_W +: CHAR_W] = wide_sel ? buf_q : '1;
  end
  assign assembled[TOP +: CHAR_W] = nxt_win;

  always_ff @(posedge clk) begin
    if (rst) begin
      word_out <= '0;
      word_vld <= 1'b0;
      sync_out <= 1'b0;
    end else begin
      word_vld <= emit;
      sync_out <= emit & word_comma & frame_en;
      if (emit) begin
        word_out <= assembled;
      end
    end
  end

  AST_SYNC_WITH_WORD: assert property (@(posedge clk) disable iff (rst)
    sync_out |-> word_vld); // R7

  AST_NARROW_PAD_ONES: assert property (@(posedge clk) disable iff (rst)
    (word_vld && !$past(wide_sel)) |-> (&word_out[TOP-1:0])); // R2

  AST_SYNC_CARRIES_COMMA: assert property (@(posedge clk) disable iff (rst)
    sync_out |-> ($past(wide_sel) ? (word_out[COMMA_W-1:0] == COMMA_PAT)
                                  : (word_out[TOP +: COMMA_W] == COMMA_PAT))); // R4
endmodule

// File: rtl/comma_deser.sv
module comma_deser #(
  parameter int                 CHAR_W    = cad_pkg::CAD_CHAR_W,
  parameter int                 COMMA_W   = cad_pkg::CAD_COMMA_W,
  parameter int                 LANES     = cad_pkg::CAD_LANES,
  parameter logic [COMMA_W-1:0] COMMA_PAT = cad_pkg::CAD_COMMA_PAT,
  localparam int LW       = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int WORD_W   = LANES * CHAR_W,
  localparam int GW       = $clog2(WORD_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_in,
  input  logic              bit_vld,
  input  logic              wide_sel,
  input  logic              frame_en,
  output logic [WORD_W-1:0] word_out,
  output logic              word_vld,
  output logic              sync_out
);
  logic [CHAR_W-1:0] nxt_win;
  logic              hit;
  logic              char_done;
  logic [LW-1:0]     lane;
  logic              emit;
  logic              word_comma;

  cad_shift #(.CHAR_W(CHAR_W)) u_shift (
    .clk     (clk),
    .rst     (rst),
    .bit_in  (bit_in),
    .bit_vld (bit_vld),
    .nxt_win (nxt_win)
  );

  cad_comma_det #(.CHAR_W(CHAR_W), .COMMA_W(COMMA_W), .COMMA_PAT(COMMA_PAT)) u_det (
    .nxt_win  (nxt_win),
    .bit_vld  (bit_vld),
    .frame_en (frame_en),
    .hit      (hit)
  );

  cad_framer #(.CHAR_W(CHAR_W), .COMMA_W(COMMA_W), .LANES(LANES)) u_framer (
    .clk        (clk),
    .rst        (rst),
    .bit_vld    (bit_vld),
    .hit        (hit),
    .wide_sel   (wide_sel),
    .char_done  (char_done),
    .lane       (lane),
    .emit       (emit),
    .word_comma (word_comma)
  );

  cad_outreg #(.CHAR_W(CHAR_W), .COMMA_W(COMMA_W), .LANES(LANES), .COMMA_PAT(COMMA_PAT)) u_out (
    .clk        (clk),
    .rst        (rst),
    .nxt_win    (nxt_win),
    .char_done  (char_done),
    .lane       (lane),
    .emit       (emit),
    .word_comma (word_comma),
    .wide_sel   (wide_sel),
    .frame_en   (frame_en),
    .word_out   (word_out),
    .word_vld   (word_vld),
    .sync_out   (sync_out)
  );

  // Accepted bits since the previous strobe, seen at the port level.
  logic [GW-1:0] spacing_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      spacing_q <= '0;
    end else if (word_vld) begin
      spacing_q <= GW'(bit_vld);
    end else if (bit_vld && spacing_q != GW'(WORD_W)) begin
      spacing_q <= spacing_q + 1'b1;
    end
  end

  AST_MIN_WORD_SPACING: assert property (@(posedge clk) disable iff (rst)
    word_vld |-> (spacing_q >= (wide_sel ? GW'(WORD_W) : GW'(CHAR_W)))); // R6

  AST_NO_SYNC_UNFRAMED: assert property (@(posedge clk) disable iff (rst)
    !$past(frame_en) |-> !sync_out); // R8

  AST_WORD_NEEDS_BIT: assert property (@(posedge clk) disable iff (rst)
    word_vld |-> $past(bit_vld)); // R10
endmodule

// File: tb/comma_deser_test.sv
module comma_deser_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bit_in = 1'b0;
  logic        bit_vld = 1'b0;
  logic        wide_sel = 1'b0;
  logic        frame_en = 1'b1;
  logic [19:0] word_out;
  logic        word_vld;
  logic        sync_out;

  comma_deser uut (
    .clk(clk), .rst(rst), .bit_in(bit_in), .bit_vld(bit_vld),
    .wide_sel(wide_sel), .frame_en(frame_en),
    .word_out(word_out), .word_vld(word_vld), .sync_out(sync_out)
  );

  always #2 clk = ~clk;

  localparam logic [9:0] COM = 10'h17C; // received 0,0,1,1,1,1,1,0,1,0
  localparam logic [9:0] NEG = 10'h283; // received 1,1,0,0,0,0,0,1,0,1

  int n_chk = 0;
  int n_fail = 0;
  logic [20:0] exp_q[$];
  string       tag_q[$];
  logic        stream[$];

  task automatic check(input bit ok, input string req, input logic [20:0] act, input logic [20:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Data characters keep bits 0, 4 and 8 clear, so no run of five ones appears.
  function automatic logic [9:0] dch(input int k);
    return (10'(k * 10'h2B7) + 10'h0E3) & ~10'h111;
  endfunction

  function automatic logic [9:0] char_at(input int s);
    logic [9:0] c;
    for (int i = 0; i < 10; i++) c[i] = stream[s + i];
    return c;
  endfunction

  task automatic add_char(input logic [9:0] c);
    for (int i = 0; i < 10; i++) stream.push_back(c[i]);
  endtask

  task automatic add_alt(input int n);
    for (int i = 0; i < n; i++) stream.push_back((i % 2) == 0);
  endtask

  task automatic exp_n(input logic [9:0] c, input logic s, input string tag);
    exp_q.push_back({s, c, 10'h3FF});
    tag_q.push_back(tag);
  endtask

  task automatic exp_w(input logic [9:0] lo, input logic [9:0] hi, input logic s, input string tag);
    exp_q.push_back({s, hi, lo});
    tag_q.push_back(tag);
  endtask

  // Scoreboard monitor: every strobe pops one expected word.
  always @(negedge clk) begin
    if (!rst && word_vld) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R6 R9 unexpected word", {sync_out, word_out}, 21'h0);
      end else begin
        logic [20:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check({sync_out, word_out} === e, t, {sync_out, word_out}, e);
      end
    end
  end

  task automatic start(input logic w, input logic f);
    @(negedge clk);
    rst = 1'b1; bit_vld = 1'b0; wide_sel = w; frame_en = f;
    stream.delete();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check({sync_out, word_vld} == 2'b00 && word_out == 20'h0, "R9 reset state",
          {sync_out, word_out}, 21'h0);
  endtask

  // Driver: plays the stream with idle cycles carrying junk on bit_in (R10).
  task automatic play();
    for (int i = 0; i < stream.size(); i++) begin
      if (i % 4 == 3) begin
        bit_vld = 1'b0;
        bit_in = ~stream[i];
        @(negedge clk);
        bit_in = $urandom_range(0, 1);
        @(negedge clk);
      end
      bit_in = stream[i];
      bit_vld = 1'b1;
      @(negedge clk);
    end
    bit_vld = 1'b0;
    repeat (6) @(negedge clk);
    check(exp_q.size() == 0, "R6 R10 all expected words delivered",
          21'(exp_q.size()), 21'h0);
    exp_q.delete();
    tag_q.delete();
  endtask

  initial begin
    repeat (2) @(negedge clk);

    // A: narrow, comma on the reset boundary.
    start(1'b0, 1'b1);
    add_char(COM); add_char(dch(1)); add_char(dch(2)); add_char(dch(3));
    exp_n(COM, 1'b1, "R7 R2 comma word");
    exp_n(dch(1), 1'b0, "R1 R10 data word");
    exp_n(dch(2), 1'b0, "R2 data word");
    exp_n(dch(3), 1'b0, "R7 no sync on data");
    play();

    // B: comma six bits off; realigned comma word would be short.
    start(1'b0, 1'b1);
    add_alt(6); add_char(COM); add_char(dch(4)); add_char(dch(5));
    add_char(COM); add_char(dch(6));
    exp_n(char_at(0), 1'b0, "R2 reset-boundary word");
    exp_n(dch(4), 1'b0, "R6 short comma word dropped");
    exp_n(dch(5), 1'b0, "R5 aligned data");
    exp_n(COM, 1'b1, "R7 aligned comma");
    exp_n(dch(6), 1'b0, "R5 after comma");
    play();

    // C: comma thirteen bits off; realigned word is long enough.
    start(1'b0, 1'b1);
    add_alt(13); add_char(COM); add_char(dch(7));
    exp_n(char_at(0), 1'b0, "R2 first word");
    exp_n(COM, 1'b1, "R5 realigned comma");
    exp_n(dch(7), 1'b0, "R5 realigned data");
    play();

    // D: wide mode, alignment, then a comma arriving in the second lane.
    start(1'b1, 1'b1);
    add_alt(3); add_char(COM); add_char(dch(1)); add_char(dch(2)); add_char(dch(3));
    add_char(COM); add_char(dch(4)); add_char(dch(5)); add_char(COM); add_char(dch(6));
    exp_w(COM, dch(1), 1'b1, "R3 R5 wide comma word");
    exp_w(dch(2), dch(3), 1'b0, "R3 wide data word");
    exp_w(COM, dch(4), 1'b1, "R7 wide aligned comma");
    exp_w(COM, dch(6), 1'b1, "R5 comma pulled to first lane");
    play();

    // E: inverted comma off the boundary must not realign.
    start(1'b0, 1'b1);
    add_alt(3); add_char(NEG); add_char(dch(8)); add_alt(7);
    exp_n(char_at(0), 1'b0, "R4 inverted comma ignored");
    exp_n(char_at(10), 1'b0, "R4 boundary kept");
    exp_n(char_at(20), 1'b0, "R4 boundary kept");
    play();

    // F: narrow, framing disabled.
    start(1'b0, 1'b0);
    add_alt(3); add_char(COM); add_char(dch(2)); add_alt(7);
    exp_n(char_at(0), 1'b0, "R8 unframed word");
    exp_n(char_at(10), 1'b0, "R8 unframed word");
    exp_n(char_at(20), 1'b0, "R8 unframed word");
    play();

    // G: wide, framing disabled.
    start(1'b1, 1'b0);
    add_alt(5); add_char(COM); add_char(dch(3)); add_char(dch(4)); add_alt(5);
    exp_w(char_at(0), char_at(10), 1'b0, "R8 R3 unframed wide");
    exp_w(char_at(20), char_at(30), 1'b0, "R8 R3 unframed wide");
    play();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #800000;
    n_chk++;
    n_fail++;
    $display("FAIL R9 watchdog: actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule